// File: doc/BRIEF.md
# Serial Byte Memory Slave Engine

This block is the slave-side protocol engine of a byte-addressable memory reached over a four-wire serial bus in clock modes 0 and 3. It runs in one system clock domain. The serial clock, select, data-in and pause inputs pass through two-flop synchronizers, and edge detectors turn them into single-cycle events. Each select frame carries one command byte. The engine then gathers a two-byte address, streams data in or out with automatic address increment over a 2048 x 8 register array, answers status and identification queries, or returns nothing for the rest of the frame.

Write permission is decided outside the block. Every memory or status write is presented to the protection unit as a one-cycle strobe carrying the address and the data. The memory array accepts the byte only while the returned permit input is high in that cycle. Write-enable set and clear commands leave the block as one-cycle strobes. The status byte to return is taken from an input. The serial output is tri-state: the block drives a data bit and a separate enable for the pad.

Top module: `spi_mem_slave`

## Requirements
- R1: Bytes travel most significant bit first. Input bits are taken on rising serial clock edges and output bits change on falling edges. Both clock-idle-low (mode 0) and clock-idle-high (mode 3) framing work.
- R2: The first byte after select falls is the command. Only one command is accepted per frame. After a finished command (for example the write-enable set code 06h), further bytes in the same frame cause no strobes and leave the output undriven.
- R3: The memory read (03h) and memory write (02h) commands take a two-byte address, high byte first. The upper 5 bits of that 16-bit field are ignored.
- R4: During a read or write stream, the address advances by one after every byte for as long as clocks continue, and 7FFh wraps to 000h.
- R5: On a memory write, each data byte causes exactly one single-cycle write strobe with the status flag low and the byte's address and data. The array stores the byte only if the permit input is high during that strobe.
- R6: Locations 7FCh to 7FFh are reserved. Reads from them return 00h, and writes to them never change storage.
- R7: Read status (05h) returns the status input byte, then leaves the output undriven. Write status (01h) issues one strobe with the status flag high carrying the next byte, and later bytes are ignored.
- R8: Codes 06h and 04h each produce exactly one single-cycle set or clear write-enable strobe, and never more than one strobe output is high at a time.
- R9: Identification read (9Fh) returns 7Fh six times, then C2h, 42h and 00h. After those nine bytes the output is undriven.
- R10: While the pause input is low, serial clock edges are ignored and the output enable is low. The transfer resumes where it stopped once the pause input returns high while the clock is low.
- R11: An unrecognized command code makes the block ignore the rest of the frame: no strobes, and the output stays undriven.
- R12: After reset, and whenever no data is being returned, the output enable is low and no strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | Serial clock from the bus master |
| cs_ni | input | 1 | Frame select, active low |
| si_i | input | 1 | Serial data in |
| hold_ni | input | 1 | Pause input, active low |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Output enable for the serial data pad |
| status_i | input | 8 | Status byte returned by the status read |
| wr_req_o | output | 1 | One-cycle write strobe to the protection unit |
| wr_stat_o | output | 1 | Marks the strobe as a status write |
| wr_addr_o | output | 11 | Address of the memory write |
| wr_data_o | output | 8 | Data of the write |
| wr_permit_i | input | 1 | Permit from the protection unit, sampled with the strobe |
| wen_set_o | output | 1 | Write-enable set strobe |
| wen_clr_o | output | 1 | Write-enable clear strobe |

## Verification
Any pin change reaches the engine's registers on the third system clock edge after it: two synchronizer stages and the edge register. A read byte that must be fetched from the array appears one clock later than that. Strobes are registered on that third edge and last one cycle. The bench holds every serial clock half-period for four system clocks and samples the outputs on the falling system clock edge after the fourth. Each bit and strobe is therefore read after it is due and before the next pin change, and the checks never race the edge that produces the result.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_OPC, ST_ADDR_HI, ST_ADDR_LO, ST_WR_DAT, ST_RD_DAT,
    ST_STAT_RD, ST_STAT_WR, ST_ID_RD, ST_SKIP
  } eng_st_e;

  localparam logic [7:0] OP_WEN_SET = 8'h06;
  localparam logic [7:0] OP_WEN_CLR = 8'h04;
  localparam logic [7:0] OP_STAT_RD = 8'h05;
  localparam logic [7:0] OP_STAT_WR = 8'h01;
  localparam logic [7:0] OP_MEM_RD  = 8'h03;
  localparam logic [7:0] OP_MEM_WR  = 8'h02;
  localparam logic [7:0] OP_ID_RD   = 8'h9F;

  localparam int ID_LEN  = 9;
  localparam int ID_PREF = 6;

  function automatic logic [7:0] id_byte(input int unsigned idx);
    if (idx < ID_PREF)      return 8'h7F;
    else if (idx == ID_PREF) return 8'hC2;
    else if (idx == ID_PREF + 1) return 8'h42;
    else                    return 8'h00;
  endfunction
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int           N       = 4,
  parameter int           STAGES  = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] level_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic [STAGES:0] chain;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain <= {(STAGES+1){RST_VAL[g]}};
      else         chain <= {chain[STAGES-1:0], async_i[g]};
    end
    assign level_o[g] = chain[STAGES-1];
    assign rise_o[g]  = chain[STAGES-1] & ~chain[STAGES];
    assign fall_o[g]  = ~chain[STAGES-1] & chain[STAGES];
  end
endmodule

// File: rtl/spi_mem_array.sv
module spi_mem_array #(
  parameter int ADDR_W = 11,
  parameter int RSVD_N = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [7:0]        wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [7:0]        rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] RSVD_BASE = ADDR_W'(DEPTH - RSVD_N);

  logic [7:0] mem [DEPTH];
  logic       w_ok;

  assign w_ok = we_i && (waddr_i < RSVD_BASE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
    end else if (w_ok) begin
      mem[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = (raddr_i < RSVD_BASE) ? mem[raddr_i] : 8'h00;
endmodule

// File: rtl/spi_mem_engine.sv
module spi_mem_engine
  import spi_mem_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_rise_i,
  input  logic              sck_fall_i,
  input  logic              cs_rise_i,
  input  logic              cs_fall_i,
  input  logic              si_i,
  input  logic              hold_ok_i,
  input  logic [7:0]        status_i,
  input  logic [7:0]        rd_data_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              so_o,
  output logic              so_oe_o,
  output logic              wr_req_o,
  output logic              wr_stat_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              wen_set_o,
  output logic              wen_clr_o
);
  localparam int HI_W  = ADDR_W - 8;
  localparam int IDX_W = $clog2(ID_LEN + 1);

  eng_st_e           state;
  logic [2:0]        bit_cnt;
  logic [6:0]        rx;
  logic [7:0]        tx;
  logic              so_q;
  logic              rd_mode;
  logic              load_pend;
  logic [ADDR_W-1:0] addr;
  logic [IDX_W-1:0]  id_idx;
  logic [7:0]        byte_in;
  logic [7:0]        id_nxt;
  logic              out_st;

  assign byte_in = {rx, si_i};
  assign id_nxt  = id_byte(32'(id_idx));
  assign out_st  = (state == ST_RD_DAT) || (state == ST_STAT_RD) || (state == ST_ID_RD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state     <= ST_IDLE;
      bit_cnt   <= '0;
      rx        <= '0;
      tx        <= '0;
      so_q      <= 1'b0;
      rd_mode   <= 1'b0;
      load_pend <= 1'b0;
      addr      <= '0;
      id_idx    <= '0;
      wr_req_o  <= 1'b0;
      wr_stat_o <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
      wen_set_o <= 1'b0;
      wen_clr_o <= 1'b0;
    end else begin
      wr_req_o  <= 1'b0;
      wr_stat_o <= 1'b0;
      wen_set_o <= 1'b0;
      wen_clr_o <= 1'b0;
      // array read port is registered-address, so fetch lags one cycle
      if (load_pend) begin
        tx        <= rd_data_i;
        so_q      <= rd_data_i[7];
        load_pend <= 1'b0;
      end
      if (hold_ok_i) begin
        if (cs_rise_i) begin
          state <= ST_IDLE;
        end else if (cs_fall_i) begin
          state   <= ST_OPC;
          bit_cnt <= '0;
        end else if (state != ST_IDLE && sck_rise_i) begin
          rx      <= byte_in[6:0];
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) begin
            unique case (state)
              ST_OPC: begin
                unique case (byte_in)
                  OP_WEN_SET: begin wen_set_o <= 1'b1; state <= ST_SKIP; end
                  OP_WEN_CLR: begin wen_clr_o <= 1'b1; state <= ST_SKIP; end
                  OP_STAT_RD: begin
                    tx    <= status_i;
                    so_q  <= status_i[7];
                    state <= ST_STAT_RD;
                  end
                  OP_STAT_WR: state <= ST_STAT_WR;
                  OP_MEM_RD:  begin rd_mode <= 1'b1; state <= ST_ADDR_HI; end
                  OP_MEM_WR:  begin rd_mode <= 1'b0; state <= ST_ADDR_HI; end
                  OP_ID_RD: begin
                    tx     <= id_byte(0);
                    so_q   <= 1'b0;
                    id_idx <= IDX_W'(1);
                    state  <= ST_ID_RD;
                  end
                  default: state <= ST_SKIP;
                endcase
              end
              ST_ADDR_HI: begin
                addr[ADDR_W-1:8] <= byte_in[HI_W-1:0];
                state            <= ST_ADDR_LO;
              end
              ST_ADDR_LO: begin
                addr[7:0] <= byte_in;
                if (rd_mode) begin
                  load_pend <= 1'b1;
                  state     <= ST_RD_DAT;
                end else begin
                  state <= ST_WR_DAT;
                end
              end
              ST_WR_DAT: begin
                wr_req_o  <= 1'b1;
                wr_addr_o <= addr;
                wr_data_o <= byte_in;
                addr      <= addr + 1'b1;
              end
              ST_RD_DAT: begin
                addr      <= addr + 1'b1;
                load_pend <= 1'b1;
              end
              ST_STAT_RD: state <= ST_SKIP;
              ST_STAT_WR: begin
                wr_req_o  <= 1'b1;
                wr_stat_o <= 1'b1;
                wr_data_o <= byte_in;
                state     <= ST_SKIP;
              end
              ST_ID_RD: begin
                if (32'(id_idx) == ID_LEN) begin
                  state <= ST_SKIP;
                end else begin
                  tx     <= id_nxt;
                  so_q   <= id_nxt[7];
                  id_idx <= id_idx + 1'b1;
                end
              end
              default: ;
            endcase
          end
        end else if (sck_fall_i && out_st) begin
          so_q <= tx[~bit_cnt];
        end
      end
    end
  end

  assign rd_addr_o = addr;
  assign so_o      = so_q;
  assign so_oe_o   = out_st && hold_ok_i;

  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_req_o, wen_set_o, wen_clr_o})); // R8
  AST_WR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o |=> !wr_req_o); // R5
  AST_ID_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(id_idx) <= ID_LEN); // R9
endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave #(
  parameter int ADDR_W      = 11,
  parameter int RSVD_N      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              cs_ni,
  input  logic              si_i,
  input  logic              hold_ni,
  output logic              so_o,
  output logic              so_oe_o,
  input  logic [7:0]        status_i,
  output logic              wr_req_o,
  output logic              wr_stat_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  input  logic              wr_permit_i,
  output logic              wen_set_o,
  output logic              wen_clr_o
);
  localparam int PIN_SCK  = 0;
  localparam int PIN_CS   = 1;
  localparam int PIN_SI   = 2;
  localparam int PIN_HOLD = 3;

  logic [3:0]        pin_lvl, pin_rise, pin_fall;
  logic [ADDR_W-1:0] rd_addr;
  logic [7:0]        rd_data;
  logic              mem_we;

  spi_in_sync #(.N(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1010)) i_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({hold_ni, si_i, cs_ni, sck_i}),
    .level_o (pin_lvl),
    .rise_o  (pin_rise),
    .fall_o  (pin_fall)
  );

  spi_mem_engine #(.ADDR_W(ADDR_W)) i_engine (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sck_rise_i (pin_rise[PIN_SCK]),
    .sck_fall_i (pin_fall[PIN_SCK]),
    .cs_rise_i  (pin_rise[PIN_CS]),
    .cs_fall_i  (pin_fall[PIN_CS]),
    .si_i       (pin_lvl[PIN_SI]),
    .hold_ok_i  (pin_lvl[PIN_HOLD]),
    .status_i   (status_i),
    .rd_data_i  (rd_data),
    .rd_addr_o  (rd_addr),
    .so_o       (so_o),
    .so_oe_o    (so_oe_o),
    .wr_req_o   (wr_req_o),
    .wr_stat_o  (wr_stat_o),
    .wr_addr_o  (wr_addr_o),
    .wr_data_o  (wr_data_o),
    .wen_set_o  (wen_set_o),
    .wen_clr_o  (wen_clr_o)
  );

  assign mem_we = wr_req_o && !wr_stat_o && wr_permit_i;

  spi_mem_array #(.ADDR_W(ADDR_W), .RSVD_N(RSVD_N)) i_array (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mem_we),
    .waddr_i (wr_addr_o),
    .wdata_i (wr_data_o),
    .raddr_i (rd_addr),
    .rdata_o (rd_data)
  );

  AST_HOLD_FLOAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pin_lvl[PIN_HOLD] |-> !so_oe_o); // R10
endmodule

// File: tb/test_spi_mem_slave.sv
module test_spi_mem_slave;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sck = 1'b0, cs_n = 1'b1, si = 1'b0, hold_n = 1'b1;
  logic        so, so_oe;
  logic [7:0]  status = 8'h8C;
  logic        permit = 1'b1;
  logic        wr_req, wr_stat, wen_set, wen_clr;
  logic [10:0] wr_addr;
  logic [7:0]  wr_data;

  int n_chk = 0, n_err = 0;
  int wr_cnt = 0, set_cnt = 0, clr_cnt = 0;
  logic        last_stat;
  logic [10:0] last_addr;
  logic [7:0]  last_data;
  logic [7:0]  mdl [2048];

  always #10 clk = ~clk;

  spi_mem_slave i_spi_mem_slave (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .cs_ni(cs_n), .si_i(si), .hold_ni(hold_n),
    .so_o(so), .so_oe_o(so_oe), .status_i(status), .wr_req_o(wr_req), .wr_stat_o(wr_stat),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data), .wr_permit_i(permit),
    .wen_set_o(wen_set), .wen_clr_o(wen_clr)
  );

  always @(posedge clk) begin
    if (wr_req) begin
      wr_cnt++; last_stat = wr_stat; last_addr = wr_addr; last_data = wr_data;
    end
    if (wen_set) set_cnt++;
    if (wen_clr) clr_cnt++;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_at(input int a);
    return (a >= 2044) ? 8'h00 : mdl[a];
  endfunction

  task automatic phase(input logic v);
    sck = v;
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cs_start(input logic m3);
    sck = m3;
    repeat (4) @(posedge clk);
    cs_n = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cs_stop();
    cs_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(so_oe == 1'b0, "R12 oe after frame", so_oe, 0);
  endtask

  task automatic xbyte(input logic [7:0] tx, input logic exp_oe, input string tag,
                       output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      si = tx[i];
      phase(1'b0);
      check(so_oe == exp_oe, tag, so_oe, exp_oe);
      rx[i] = so;
      phase(1'b1);
    end
  endtask

  task automatic mem_wr(input logic m3, input logic [15:0] a16, input int n,
                        input logic [7:0] base, input string tag);
    logic [7:0] rx;
    int a;
    cs_start(m3);
    xbyte(8'h02, 1'b0, tag, rx);
    xbyte(a16[15:8], 1'b0, tag, rx);
    xbyte(a16[7:0], 1'b0, tag, rx);
    a = int'(a16[10:0]);
    for (int k = 0; k < n; k++) begin
      logic [7:0] d;
      int c0;
      d = base + 8'(8'h11 * k);
      c0 = wr_cnt;
      xbyte(d, 1'b0, tag, rx);
      check(wr_cnt == c0 + 1, {tag, " R5 strobe count"}, wr_cnt, c0 + 1);
      check(last_addr == 11'(a) && last_data == d && !last_stat, {tag, " R5 strobe addr"},
            {last_addr, last_data}, {11'(a), d});
      if (permit && a < 2044) mdl[a] = d;
      a = (a + 1) % 2048;
    end
    cs_stop();
  endtask

  task automatic mem_rd(input logic m3, input logic [15:0] a16, input int n, input string tag);
    logic [7:0] rx;
    int a;
    cs_start(m3);
    xbyte(8'h03, 1'b0, tag, rx);
    xbyte(a16[15:8], 1'b0, tag, rx);
    xbyte(a16[7:0], 1'b0, tag, rx);
    a = int'(a16[10:0]);
    for (int k = 0; k < n; k++) begin
      xbyte(8'h5A ^ 8'(k), 1'b1, tag, rx);
      check(rx == exp_at(a), {tag, " read data"}, rx, exp_at(a));
      a = (a + 1) % 2048;
    end
    cs_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog act=0 exp=1");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [7:0] rx;
    int c0;
    for (int i = 0; i < 2048; i++) mdl[i] = 8'h00;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(so_oe == 1'b0 && wr_cnt == 0 && set_cnt == 0, "R12 reset state", so_oe, 0);

    // R8 set strobe, R2 trailing byte ignored
    cs_start(1'b0);
    xbyte(8'h06, 1'b0, "R8 set", rx);
    check(set_cnt == 1 && clr_cnt == 0, "R8 set strobe", set_cnt, 1);
    xbyte(8'h03, 1'b0, "R2 extra byte oe", rx);
    check(wr_cnt == 0 && set_cnt == 1 && clr_cnt == 0, "R2 no strobes", set_cnt, 1);
    cs_stop();

    // R8 clear strobe in mode 3 (R1)
    cs_start(1'b1);
    xbyte(8'h04, 1'b0, "R1 mode3 clr", rx);
    check(clr_cnt == 1 && set_cnt == 1, "R8 clr strobe", clr_cnt, 1);
    cs_stop();

    // R3 upper address bits ignored on write, R5 strobes
    mem_wr(1'b0, 16'hF810, 3, 8'h11, "R3 write");
    mem_rd(1'b0, 16'h0010, 4, "R4 R1 mode0 stream");
    mem_rd(1'b1, 16'hA811, 2, "R1 R3 mode3");

    // R5 permit low: strobe but no store
    permit = 1'b0;
    mem_wr(1'b0, 16'h0020, 1, 8'h5A, "R5 denied");
    permit = 1'b1;
    mem_rd(1'b0, 16'h0020, 1, "R5 denied readback");

    // R6 R4 reserved drop and wrap to 000h
    mem_wr(1'b0, 16'h07FE, 3, 8'h44, "R6 R4 write wrap");
    mem_wr(1'b1, 16'h07FA, 3, 8'h98, "R6 write edge");
    mem_rd(1'b0, 16'h07FA, 7, "R6 R4 read wrap");

    // R7 status read, one byte then undriven
    cs_start(1'b0);
    xbyte(8'h05, 1'b0, "R7 stat cmd", rx);
    xbyte(8'h00, 1'b1, "R7 stat oe", rx);
    check(rx == status, "R7 status byte", rx, status);
    xbyte(8'h00, 1'b0, "R7 stat after byte oe", rx);
    cs_stop();

    // R7 status write, one strobe only
    cs_start(1'b0);
    xbyte(8'h01, 1'b0, "R7 wstat cmd", rx);
    c0 = wr_cnt;
    xbyte(8'hA5, 1'b0, "R7 wstat data", rx);
    check(wr_cnt == c0 + 1 && last_stat && last_data == 8'hA5, "R7 status strobe",
          last_data, 8'hA5);
    xbyte(8'h3C, 1'b0, "R7 wstat extra", rx);
    check(wr_cnt == c0 + 1, "R7 R2 no second strobe", wr_cnt, c0 + 1);
    cs_stop();

    // R9 identification stream
    cs_start(1'b1);
    xbyte(8'h9F, 1'b0, "R9 id cmd", rx);
    for (int k = 0; k < 9; k++) begin
      logic [7:0] e;
      e = (k < 6) ? 8'h7F : (k == 6) ? 8'hC2 : (k == 7) ? 8'h42 : 8'h00;
      xbyte(8'h00, 1'b1, "R9 id oe", rx);
      check(rx == e, "R9 id byte", rx, e);
    end
    xbyte(8'h00, 1'b0, "R9 id end oe", rx);
    cs_stop();

    // R11 unknown opcode
    cs_start(1'b0);
    c0 = wr_cnt;
    xbyte(8'h55, 1'b0, "R11 unknown", rx);
    xbyte(8'h02, 1'b0, "R11 ignored byte", rx);
    xbyte(8'h00, 1'b0, "R11 ignored byte", rx);
    check(wr_cnt == c0 && set_cnt == 1 && clr_cnt == 1, "R11 no strobes", wr_cnt, c0);
    cs_stop();

    // R10 pause during a read
    cs_start(1'b0);
    xbyte(8'h03, 1'b0, "R10 cmd", rx);
    xbyte(8'h00, 1'b0, "R10 ahi", rx);
    xbyte(8'h10, 1'b0, "R10 alo", rx);
    xbyte(8'h00, 1'b1, "R10 first byte", rx);
    check(rx == exp_at(16), "R10 first byte", rx, exp_at(16));
    phase(1'b0);
    hold_n = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(so_oe == 1'b0, "R10 oe in pause", so_oe, 0);
    for (int k = 0; k < 3; k++) begin
      phase(1'b1);
      check(so_oe == 1'b0, "R10 oe in pause", so_oe, 0);
      phase(1'b0);
    end
    hold_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(so_oe == 1'b1, "R10 resume oe", so_oe, 1);
    rx[7] = so;
    phase(1'b1);
    for (int i = 6; i >= 0; i--) begin
      phase(1'b0);
      rx[i] = so;
      phase(1'b1);
    end
    check(rx == exp_at(17), "R10 resumed byte", rx, exp_at(17));
    cs_stop();

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule